// File: doc/BRIEF.md
# Configuration Memory Clear Controller

This block sequences a programmable device from power-up, or from a reprogram request, to the point where a bitstream may be loaded. It steps a frame address across every configuration frame with a clear strobe. It keeps looping over whole passes while the active-low program request is held or the power-on timeout is still asserted. When a pass ends with both inactive, it runs one more full pass and then stops clearing.

Once clearing stops, the block releases its pull-down on the shared open-drain init line. It then waits for that line to read high, because another device may still be holding it low. In master builds, init must stay high for a programmable settling window before it counts as released. Two clocks after that, the block captures the mode pins and raises `cfg_start`.

A new low on `program_n` in any state sends the block back to clearing.

Top module: `cfg_clear_ctrl`

## Requirements
- R1: While `rst_n` is low, `frame_addr` is 0, `frame_clear_en` is 1, `init_drive_low` is 1 and `cfg_start` is 0.
- R2: While `frame_clear_en` is high, `frame_addr` advances by one on each clock edge and wraps from FRAMES-1 to 0.
- R3: At a clock edge where the last frame address is being cleared, clearing loops back for a new pass if `program_n` is low or `por_timeout` is high. Otherwise the block runs exactly one further full pass of FRAMES cycles, and then `frame_clear_en` falls.
- R4: In the same cycle that `program_n` is low, `init_drive_low` is high. Clearing continues, pass after pass, for as long as `program_n` stays low.
- R5: `init_drive_low` is high throughout every clearing pass, including the extra pass. It is low once clearing has ended, as long as `program_n` is high.
- R6: After clearing ends, `cfg_start` stays low for as long as `init_in` reads low.
- R7: In a master build, `cfg_start` rises exactly SETTLE_CYC+3 clock edges after the first edge that samples `init_in` high, provided `init_in` stays high throughout. A low on `init_in` during the settling window restarts that window.
- R8: `mode_latched` takes the value of `mode` on the edge where `cfg_start` rises. It holds that value while `cfg_start` stays high, whatever `mode` does.
- R9: If `program_n` is low at an edge while the block is not in the first clearing loop, then after that edge `frame_clear_en` is 1, `frame_addr` is 0 and `cfg_start` is 0.
- R10: `frame_clear_en` and `cfg_start` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| program_n | input | 1 | Active-low reprogram request |
| por_timeout | input | 1 | High while the power-on timeout is still running |
| init_in | input | 1 | Level read back from the open-drain init line |
| mode | input | 3 | Configuration mode pins |
| frame_addr | output | $clog2(FRAMES) | Frame currently being cleared |
| frame_clear_en | output | 1 | Clear strobe for the addressed frame |
| init_drive_low | output | 1 | Enables the pull-down on the init line |
| mode_latched | output | 3 | Mode pins captured at configuration start |
| cfg_start | output | 1 | Configuration may begin |

## Verification
The bench builds the block as a master with FRAMES=8 and SETTLE_CYC=16. With these values a full pass takes eight cycles, so several pass boundaries, the extra pass and a mid-pass release of the timeout fit into a few hundred cycles. The settling window is short enough that its exact length can be counted edge by edge. It is also long enough that a glitch on init inside it, followed by the restart, can be seen. The abort test then repeats the whole sequence after a reprogram request and captures a different mode value.

// File: rtl/cfg_clr_pkg.sv
package cfg_clr_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR  = 3'd0,
    ST_FINAL  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_SYNC   = 3'd4,
    ST_READY  = 3'd5
  } clr_state_t;

  localparam int unsigned SYNC_EDGES = 2;
endpackage

// File: rtl/cfg_clr_addr_gen.sv
module cfg_clr_addr_gen #(
  parameter int unsigned FRAMES = 8,
  localparam int unsigned AW = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;

  assign last = (addr_q == AW'(FRAMES - 1));
  assign addr = addr_q;

  always_comb begin
    addr_d = addr_q;
    if (restart) begin
      addr_d = '0;
    end else if (run) begin
      addr_d = last ? '0 : addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/cfg_clr_timer.sv
module cfg_clr_timer #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign done = en && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = done ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/cfg_clr_fsm.sv
module cfg_clr_fsm
  import cfg_clr_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       program_n,
  input  logic       por_timeout,
  input  logic       init_in,
  input  logic       pass_last,
  input  logic       settle_done,
  input  logic       sync_done,
  output clr_state_t state,
  output logic       clearing,
  output logic       addr_restart,
  output logic       capture
);
  clr_state_t st_q;
  clr_state_t st_d;

  assign state        = st_q;
  assign clearing     = (st_q == ST_CLEAR) || (st_q == ST_FINAL);
  assign addr_restart = !program_n && (st_q != ST_CLEAR);
  assign capture      = (st_q == ST_SYNC) && sync_done && program_n;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CLEAR: begin
        if (pass_last && program_n && !por_timeout) begin
          st_d = ST_FINAL;
        end
      end
      ST_FINAL: begin
        if (pass_last) begin
          st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (init_in) begin
          st_d = IS_MASTER ? ST_SETTLE : ST_SYNC;
        end
      end
      ST_SETTLE: begin
        if (!init_in) begin
          st_d = ST_WAIT;
        end else if (settle_done) begin
          st_d = ST_SYNC;
        end
      end
      ST_SYNC: begin
        if (sync_done) begin
          st_d = ST_READY;
        end
      end
      ST_READY: st_d = ST_READY;
      default:  st_d = ST_CLEAR;
    endcase
    if (!program_n) begin
      st_d = ST_CLEAR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_CLEAR;
    end else begin
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/cfg_clear_ctrl.sv
module cfg_clear_ctrl
  import cfg_clr_pkg::*;
#(
  parameter int unsigned FRAMES     = 8,
  parameter int unsigned SETTLE_CYC = 16,
  parameter bit          IS_MASTER  = 1'b1,
  localparam int unsigned AW = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          program_n,
  input  logic          por_timeout,
  input  logic          init_in,
  input  logic [2:0]    mode,
  output logic [AW-1:0] frame_addr,
  output logic          frame_clear_en,
  output logic          init_drive_low,
  output logic [2:0]    mode_latched,
  output logic          cfg_start
);
  clr_state_t state;
  logic       clearing;
  logic       addr_restart;
  logic       capture;
  logic       pass_last;
  logic       settle_done;
  logic       sync_done;
  logic [2:0] mode_q;
  logic [2:0] mode_d;

  cfg_clr_fsm #(.IS_MASTER(IS_MASTER)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .program_n    (program_n),
    .por_timeout  (por_timeout),
    .init_in      (init_in),
    .pass_last    (pass_last),
    .settle_done  (settle_done),
    .sync_done    (sync_done),
    .state        (state),
    .clearing     (clearing),
    .addr_restart (addr_restart),
    .capture      (capture)
  );

  cfg_clr_addr_gen #(.FRAMES(FRAMES)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (clearing),
    .restart (addr_restart),
    .addr    (frame_addr),
    .last    (pass_last)
  );

  generate
    if (IS_MASTER && (SETTLE_CYC > 0)) begin : g_settle
      cfg_clr_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_SETTLE),
        .en    ((state == ST_SETTLE) && init_in),
        .done  (settle_done)
      );
    end else begin : g_no_settle
      assign settle_done = 1'b1;
    end
  endgenerate

  cfg_clr_timer #(.LIMIT(SYNC_EDGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state != ST_SYNC),
    .en    (state == ST_SYNC),
    .done  (sync_done)
  );

  always_comb begin
    mode_d = mode_q;
    if (capture) begin
      mode_d = mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign frame_clear_en = clearing;
  assign init_drive_low = clearing || !program_n;
  assign mode_latched   = mode_q;
  assign cfg_start      = (state == ST_READY);
endmodule

// File: rtl/cfg_clear_ctrl_chk.sv
module cfg_clear_ctrl_chk #(
  parameter int unsigned FRAMES = 8,
  localparam int unsigned AW = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          program_n,
  input logic          por_timeout,
  input logic [AW-1:0] frame_addr,
  input logic          frame_clear_en,
  input logic          init_drive_low,
  input logic [2:0]    mode_latched,
  input logic          cfg_start
);
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_clear_en && program_n && frame_addr != AW'(FRAMES - 1))
      |=> (frame_clear_en && frame_addr == AW'($past(frame_addr) + 1'b1)));

  a_r3_pass_loops: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_clear_en && frame_addr == AW'(FRAMES - 1) && (!program_n || por_timeout))
      |=> (frame_clear_en && frame_addr == '0));

  a_r4_init_on_prog: assert property (@(posedge clk) disable iff (!rst_n)
    !program_n |-> init_drive_low);

  a_r5_init_while_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clear_en |-> init_drive_low);

  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_start && program_n) |=> (cfg_start && $stable(mode_latched)));

  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!program_n && cfg_start) |=> (!cfg_start && frame_clear_en && frame_addr == '0));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_clear_en && cfg_start));
endmodule

bind cfg_clear_ctrl cfg_clear_ctrl_chk #(.FRAMES(FRAMES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .program_n      (program_n),
  .por_timeout    (por_timeout),
  .frame_addr     (frame_addr),
  .frame_clear_en (frame_clear_en),
  .init_drive_low (init_drive_low),
  .mode_latched   (mode_latched),
  .cfg_start      (cfg_start)
);

// File: tb/sim_cfg_clear_ctrl.sv
module sim_cfg_clear_ctrl;
  localparam int F  = 8;
  localparam int D  = 16;
  localparam int AW = $clog2(F);

  logic          clk;
  logic          rst_n;
  logic          program_n;
  logic          por_timeout;
  logic          init_in;
  logic [2:0]    mode;
  logic [AW-1:0] frame_addr;
  logic          frame_clear_en;
  logic          init_drive_low;
  logic [2:0]    mode_latched;
  logic          cfg_start;

  int n_run;
  int n_fail;

  cfg_clear_ctrl #(.FRAMES(F), .SETTLE_CYC(D), .IS_MASTER(1'b1)) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .program_n      (program_n),
    .por_timeout    (por_timeout),
    .init_in        (init_in),
    .mode           (mode),
    .frame_addr     (frame_addr),
    .frame_clear_en (frame_clear_en),
    .init_drive_low (init_drive_low),
    .mode_latched   (mode_latched),
    .cfg_start      (cfg_start)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "addr in reset", int'(frame_addr), 0);
    check("R1", "clear_en in reset", int'(frame_clear_en), 1);
    check("R1", "init_drive_low in reset", int'(init_drive_low), 1);
    check("R1", "cfg_start in reset", int'(cfg_start), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_addr_walk();
    int bad = 0;
    for (int i = 0; i < 2 * F; i++) begin
      if (int'(frame_addr) != (i % F) || !frame_clear_en) bad++;
      @(negedge clk);
    end
    check("R2", "address walk mismatches", bad, 0);
  endtask

  task automatic t_por_hold();
    int lows = 0;
    for (int i = 0; i < 5 * F; i++) begin
      if (!frame_clear_en || cfg_start || !init_drive_low) lows++;
      @(negedge clk);
    end
    check("R3", "cycles not clearing while timeout high", lows, 0);
  endtask

  // Release a hold (already applied by caller) and count clearing cycles.
  task automatic count_clear(input int a, input string req);
    int n = 0;
    int initlow = 0;
    for (int i = 0; i < 6 * F && frame_clear_en; i++) begin
      n++;
      if (!init_drive_low) initlow++;
      @(negedge clk);
    end
    check(req, "clear cycles after release", n, (F - a) + F);
    check("R5", "init released during clearing", initlow, 0);
    check("R5", "init_drive_low after clearing", int'(init_drive_low), 0);
  endtask

  task automatic t_final_pass();
    int a;
    repeat (3) @(negedge clk);
    a = int'(frame_addr);
    por_timeout = 1'b0;
    count_clear(a, "R3");
  endtask

  task automatic t_init_held();
    int starts = 0;
    for (int i = 0; i < 3 * D; i++) begin
      @(negedge clk);
      if (cfg_start || frame_clear_en) starts++;
    end
    check("R6", "starts while init held low", starts, 0);
  endtask

  task automatic t_settle();
    int bad = 0;
    init_in = 1'b1;
    for (int i = 0; i < D / 2; i++) begin
      @(negedge clk);
      if (cfg_start) bad++;
    end
    init_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R7", "cfg_start during glitch window", bad + int'(cfg_start), 0);
    init_in = 1'b1;
    bad = 0;
    for (int k = 1; k <= D + 5; k++) begin
      @(negedge clk);
      if (int'(cfg_start) != int'(k >= D + 3)) bad++;
    end
    check("R7", "settle timing mismatches", bad, 0);
    check("R8", "captured mode", int'(mode_latched), 5);
    mode = 3'b010;
    repeat (4) @(negedge clk);
    check("R8", "mode held after pins change", int'(mode_latched), 5);
    check("R8", "cfg_start held", int'(cfg_start), 1);
  endtask

  task automatic t_abort();
    int lows = 0;
    int a;
    int k = 0;
    program_n = 1'b0;
    #1;
    check("R4", "init_drive_low same cycle", int'(init_drive_low), 1);
    @(negedge clk);
    check("R9", "cfg_start after abort", int'(cfg_start), 0);
    check("R9", "clear_en after abort", int'(frame_clear_en), 1);
    check("R9", "addr after abort", int'(frame_addr), 0);
    for (int i = 0; i < 3 * F; i++) begin
      @(negedge clk);
      if (!frame_clear_en || !init_drive_low) lows++;
    end
    check("R4", "gaps while program held low", lows, 0);
    a = int'(frame_addr);
    program_n = 1'b1;
    count_clear(a, "R4");
    while (!cfg_start && k < 4 * D) begin
      @(negedge clk);
      k++;
    end
    check("R7", "edges to restart after abort", k, D + 3);
    check("R8", "recaptured mode", int'(mode_latched), 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    rst_n = 1'b0;
    program_n = 1'b1;
    por_timeout = 1'b1;
    init_in = 1'b0;
    mode = 3'b101;
    repeat (2) @(negedge clk);
    t_reset();
    t_addr_walk();
    t_por_hold();
    t_final_pass();
    t_init_held();
    t_settle();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule